// File: doc/BRIEF.md
# Double-Word Bit-Field Extract and Insert Unit

This block pulls a bit field out of a pair of 32-bit words, or drops a field into a word, under the control of a small field descriptor. The two operand words are treated as one 64-bit value with the high word on the left. That value is rotated up by a 5-bit shift amount, and the upper 32 bits form a window. A mask then trims the window. In extract mode the result is a field of the chosen width, aligned to bit 0. In insert mode, bits of the window land in the right-hand word while the remaining bits of that word are kept.

The descriptor has three parts: a 5-bit shift amount, a 6-bit field width (0 to 63), and a one-bit mode select (0 = extract, 1 = insert). With the default setting, the result passes through one output register stage, so a result appears one clock after its operands. A parameter can remove that stage and leave a purely combinational path.

Top module: `bitfield_unit`

## Requirements
- R1: The window is bits [63:32] of the 64-bit value {hi_word_i, lo_word_i} shifted left by shamt_i; bits shifted in from below are zero. With width_i = 32 in extract mode, the result equals the window for every shamt_i from 0 to 31.
- R2: With shamt_i = 0, the window equals hi_word_i.
- R3: Any width_i from 32 through 63 gives a mask of all ones.
- R4: In extract mode (insert_i = 0) with width_i below 32, the result is the window ANDed with width_i ones aligned to bit 0, and every result bit at or above position width_i is 0.
- R5: In extract mode, width_i = 0 gives a result of zero.
- R6: In insert mode (insert_i = 1), the mask is the width_i-ones mask with its lowest shamt_i bits cleared. Each result bit takes the window bit where the mask is 1 and the lo_word_i bit where the mask is 0. The lowest shamt_i result bits therefore always equal lo_word_i.
- R7: In insert mode, width_i = 0 returns lo_word_i unchanged.
- R8: In insert mode, any width_i not greater than shamt_i returns lo_word_i unchanged.
- R9: With the output stage present (default), field_o shows the result for the operands present at the previous rising clock edge. While rst_n is low, field_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| hi_word_i | input | 32 | Upper operand word of the 64-bit shift source |
| lo_word_i | input | 32 | Lower operand word; also the destination word in insert mode |
| shamt_i | input | 5 | Left shift amount, 0 to 31 |
| width_i | input | 6 | Field width in bits, 0 to 63 (32 and above means full word) |
| insert_i | input | 1 | Mode: 0 = extract, 1 = insert |
| field_o | output | 32 | Extracted field or merged word |

## Verification
The hardest cases to reach are the insert cases where the shift clears every bit of the mask: the width is non-zero but no larger than the shift amount. In those cases the output must fall back to the destination word. The same applies to the maximum shift of 31, where only one window bit comes from the upper word. The stimulus table targets both cases with hand-worked vectors. Widths from 33 to 63 exercise the saturation of the mask. A long run of pseudo-random descriptors and operands then covers every mix of shift, width and mode, compared against a bit-by-bit model.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int unsigned BF_W   = 32;
    localparam int unsigned BF_SHW = $clog2(BF_W);
    localparam int unsigned BF_MW  = BF_SHW + 1;

    typedef struct packed {
        logic              insert;
        logic [BF_MW-1:0]  width;
        logic [BF_SHW-1:0] shamt;
    } bf_desc_t;
endpackage

// File: rtl/bf_funnel.sv
module bf_funnel #(
    parameter int unsigned W   = 32,
    parameter int unsigned SHW = 5
) (
    input  logic [W-1:0]   hi_i,
    input  logic [W-1:0]   lo_i,
    input  logic [SHW-1:0] sh_i,
    output logic [W-1:0]   win_o
);
    localparam int unsigned DW = 2 * W;

    logic [SHW:0][DW-1:0] stage;

    assign stage[0] = {hi_i, lo_i};

    // Logarithmic shifter: stage s moves the value by 2**s when sh_i[s] is set.
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        assign stage[s+1] = sh_i[s] ? (stage[s] << (2 ** s)) : stage[s];
    end

    assign win_o = stage[SHW][DW-1:W];

    logic unused_low;
    assign unused_low = ^stage[SHW][W-1:0];
endmodule

// File: rtl/bf_maskgen.sv
module bf_maskgen #(
    parameter int unsigned W   = 32,
    parameter int unsigned SHW = 5,
    parameter int unsigned MW  = 6
) (
    input  logic [MW-1:0]  width_i,
    input  logic [SHW-1:0] sh_i,
    input  logic           insert_i,
    output logic [W-1:0]   mask_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [MW-1:0]  IDX_M = MW'(i);
        localparam logic [SHW-1:0] IDX_S = SHW'(i);
        logic in_field;
        logic above_shift;
        // Width at or beyond W saturates: every position is below it.
        assign in_field    = (width_i > IDX_M);
        assign above_shift = (sh_i <= IDX_S);
        assign mask_o[i]   = in_field & (~insert_i | above_shift);
    end
endmodule

// File: rtl/bf_merge.sv
module bf_merge #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] win_i,
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] mask_i,
    input  logic         insert_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        if (insert_i) begin
            res_o = (win_i & mask_i) | (dst_i & ~mask_i);
        end else begin
            res_o = win_i & mask_i;
        end
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bf_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BF_W-1:0]     hi_word_i,
    input  logic [BF_W-1:0]     lo_word_i,
    input  logic [BF_SHW-1:0]   shamt_i,
    input  logic [BF_MW-1:0]    width_i,
    input  logic                insert_i,
    output logic [BF_W-1:0]     field_o
);
    bf_desc_t        desc;
    logic [BF_W-1:0] window;
    logic [BF_W-1:0] mask;
    logic [BF_W-1:0] result;

    assign desc = '{insert: insert_i, width: width_i, shamt: shamt_i};

    bf_funnel #(.W(BF_W), .SHW(BF_SHW)) funnel_i (
        .hi_i  (hi_word_i),
        .lo_i  (lo_word_i),
        .sh_i  (desc.shamt),
        .win_o (window)
    );

    bf_maskgen #(.W(BF_W), .SHW(BF_SHW), .MW(BF_MW)) maskgen_i (
        .width_i  (desc.width),
        .sh_i     (desc.shamt),
        .insert_i (desc.insert),
        .mask_o   (mask)
    );

    bf_merge #(.W(BF_W)) merge_i (
        .win_i    (window),
        .dst_i    (lo_word_i),
        .mask_i   (mask),
        .insert_i (desc.insert),
        .res_o    (result)
    );

    if (REG_OUT) begin : g_reg
        logic [BF_W-1:0] field_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q <= '0;
            end else begin
                field_q <= result;
            end
        end
        assign field_o = field_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign field_o    = result;
    end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk
    import bf_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BF_W-1:0]   hi_word_i,
    input logic [BF_W-1:0]   lo_word_i,
    input logic [BF_SHW-1:0] shamt_i,
    input logic [BF_MW-1:0]  width_i,
    input logic              insert_i,
    input logic [BF_W-1:0]   field_o
);
    logic [BF_W-1:0]   c_lo;
    logic [BF_SHW-1:0] c_sh;
    logic [BF_MW-1:0]  c_w;
    logic              c_ins;
    logic              armed;

    if (REG_OUT) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_lo  <= '0;
                c_sh  <= '0;
                c_w   <= '0;
                c_ins <= 1'b0;
                armed <= 1'b0;
            end else begin
                c_lo  <= lo_word_i;
                c_sh  <= shamt_i;
                c_w   <= width_i;
                c_ins <= insert_i;
                armed <= 1'b1;
            end
        end
    end else begin : g_now
        assign c_lo  = lo_word_i;
        assign c_sh  = shamt_i;
        assign c_w   = width_i;
        assign c_ins = insert_i;
        assign armed = 1'b1;
    end

    logic unused_hi;
    assign unused_hi = ^hi_word_i;

    AST_EXTRACT_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!c_ins && c_w == '0) |-> field_o == '0); // R5

    AST_EXTRACT_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!c_ins && c_w < BF_MW'(BF_W)) |-> (field_o >> c_w) == '0); // R4

    AST_INSERT_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (c_ins && c_w == '0) |-> field_o == c_lo); // R7

    AST_INSERT_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (c_ins && c_w <= BF_MW'(c_sh)) |-> field_o == c_lo); // R8

    AST_INSERT_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        c_ins |-> ((field_o ^ c_lo) & ~({BF_W{1'b1}} << c_sh)) == '0); // R6
endmodule

bind bitfield_unit bitfield_unit_chk #(.REG_OUT(REG_OUT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_word_i (hi_word_i),
    .lo_word_i (lo_word_i),
    .shamt_i   (shamt_i),
    .width_i   (width_i),
    .insert_i  (insert_i),
    .field_o   (field_o)
);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
    import bf_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 13;
    localparam int  NRAND      = 300;
    localparam int  WATCHDOG   = 20000;

    typedef struct packed {
        logic              ins;
        logic [BF_SHW-1:0] sh;
        logic [BF_MW-1:0]  w;
        logic [31:0]       hi;
        logic [31:0]       lo;
        logic [31:0]       exp;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 5'd0,  6'd32, 32'h12345678, 32'h9ABCDEF0, 32'h12345678}, // R2
        '{1'b0, 5'd8,  6'd32, 32'h12345678, 32'h9ABCDEF0, 32'h3456789A}, // R1
        '{1'b0, 5'd8,  6'd8,  32'h12345678, 32'h9ABCDEF0, 32'h0000009A}, // R4
        '{1'b0, 5'd4,  6'd12, 32'h12345678, 32'h9ABCDEF0, 32'h00000789}, // R4
        '{1'b0, 5'd4,  6'd0,  32'h12345678, 32'h9ABCDEF0, 32'h00000000}, // R5
        '{1'b0, 5'd16, 6'd40, 32'h12345678, 32'h9ABCDEF0, 32'h56789ABC}, // R3
        '{1'b1, 5'd8,  6'd16, 32'h12345678, 32'h9ABCDEF0, 32'h9ABC78F0}, // R6
        '{1'b1, 5'd3,  6'd0,  32'h12345678, 32'h9ABCDEF0, 32'h9ABCDEF0}, // R7
        '{1'b1, 5'd12, 6'd12, 32'h12345678, 32'h9ABCDEF0, 32'h9ABCDEF0}, // R8
        '{1'b1, 5'd0,  6'd32, 32'h12345678, 32'h9ABCDEF0, 32'h12345678}, // R6
        '{1'b1, 5'd16, 6'd63, 32'h12345678, 32'h9ABCDEF0, 32'h5678DEF0}, // R3
        '{1'b0, 5'd31, 6'd4,  32'h12345678, 32'h9ABCDEF0, 32'h00000008}, // R1
        '{1'b1, 5'd31, 6'd32, 32'h12345678, 32'h9ABCDEF0, 32'h1ABCDEF0}  // R6
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       hi_word = '0;
    logic [31:0]       lo_word = '0;
    logic [BF_SHW-1:0] shamt = '0;
    logic [BF_MW-1:0]  width = '0;
    logic              insert = 1'b0;
    logic [31:0]       field;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    string vec_req [NVEC] = '{"R2", "R1", "R4", "R4", "R5", "R3", "R6",
                              "R7", "R8", "R6", "R3", "R1", "R6"};

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitfield_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_word_i (hi_word),
        .lo_word_i (lo_word),
        .shamt_i   (shamt),
        .width_i   (width),
        .insert_i  (insert),
        .field_o   (field)
    );

    // Bit-level model built from the requirement text.
    function automatic logic [31:0] model(input logic ins, input int sh, input int w,
                                          input logic [31:0] hi, input logic [31:0] lo);
        logic [63:0] cat;
        logic [31:0] r;
        cat = {hi, lo};
        for (int i = 0; i < 32; i++) begin
            logic wb;
            logic m;
            wb = cat[i + 32 - sh];
            m  = (i < w) && (!ins || i >= sh);
            r[i] = m ? wb : (ins ? lo[i] : 1'b0);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run(input logic ins, input int sh, input int w,
                       input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] exp, input string req);
        @(negedge clk);
        insert  = ins;
        shamt   = BF_SHW'(sh);
        width   = BF_MW'(w);
        hi_word = hi;
        lo_word = lo;
        @(negedge clk);
        check(req, field, exp);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] prev;

        // R9: output held at zero while reset is low, even with live operands.
        hi_word = 32'hFFFFFFFF;
        lo_word = 32'hA5A5A5A5;
        width   = 6'd32;
        repeat (3) @(negedge clk);
        check("R9 reset", field, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            run(VEC[v].ins, int'(VEC[v].sh), int'(VEC[v].w),
                VEC[v].hi, VEC[v].lo, VEC[v].exp, vec_req[v]);
        end

        // R9: one clock of latency; new operands do not show before the edge.
        run(1'b0, 0, 32, 32'hCAFEF00D, 32'h0, 32'hCAFEF00D, "R9 settle");
        @(negedge clk);
        hi_word = 32'h0BADBEEF;
        #1;
        check("R9 hold", field, 32'hCAFEF00D);
        @(negedge clk);
        check("R9 update", field, 32'h0BADBEEF);

        // R8: every width up to the shift in insert mode leaves the destination.
        for (int w = 1; w <= 20; w++) begin
            run(1'b1, 20, w, 32'hFFFFFFFF, 32'h13579BDF, 32'h13579BDF, "R8 sweep");
        end

        // R3: all saturating widths behave as the full word.
        for (int w = 32; w < 64; w++) begin
            run(1'b0, 5, w, 32'h12345678, 32'h9ABCDEF0,
                model(1'b0, 5, 32, 32'h12345678, 32'h9ABCDEF0), "R3 sweep");
        end

        // R1, R4, R6: pseudo-random operands and descriptors.
        seed = 32'h2545F491;
        for (int n = 0; n < NRAND; n++) begin
            logic [31:0] a;
            logic [31:0] b;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            a = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            b = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            prev = seed;
            run(prev[0], int'(prev[5:1]), int'(prev[11:6]), a, b,
                model(prev[0], int'(prev[5:1]), int'(prev[11:6]), a, b),
                prev[0] ? "R6 random" : "R4 random");
        end

        // R9: asserting reset clears the held result.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async clear", field, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule